// File: doc/BRIEF.md
# Dual Biquinary Decade Counter

The block holds two independent counting channels. Each channel has a binary stage that divides by two and a quinary stage that divides by five. Each stage has its own count input and advances on a falling edge of that input. Each channel also has its own clear input. The stages are not tied together inside the block, so the user chooses the chaining outside it. Routing the binary output into the quinary count input gives a decade count in BCD. Routing the quinary top bit into the binary count input gives a biquinary count, in which the binary output is a square wave at one tenth of the input rate. Chaining one channel's decade into the other gives division by up to 100.

All logic runs on one system clock. Each count input passes through a two-flop synchroniser and a falling-edge detector. The detector turns a high-to-low transition into a one-cycle advance enable. A clear input takes effect asynchronously and is released on the system clock.

The quinary stage is a state machine with states QS_ZERO, QS_ONE, QS_TWO, QS_THREE and QS_FOUR, coded 0 to 4. On an enable it takes the transitions ZERO→ONE, ONE→TWO, TWO→THREE and THREE→FOUR, and the wrap FOUR→ZERO. The binary stage has two states, BS_LOW and BS_HIGH, and swaps between them on each enable. Both machines hold their state when there is no enable, and both return to their zero state on reset.

Top module: `dbq_dual_counter`

## Requirements
- R1: While the system reset `rst_n` is low, and after it is released, every output reads 0 until a count edge arrives.
- R2: Each falling edge on `tick_two[c]` inverts `out_two[c]`. Rising edges leave it unchanged.
- R3: Falling edges on `tick_five[c]` step `out_five[3c+2:3c]` through 0,1,2,3,4 and then back to 0. The value is plain binary with bit 3c+2 most significant, so that bit is high only at count 4.
- R4: Within a channel the stages are separate: `tick_two` never changes `out_five`, and `tick_five` never changes `out_two`.
- R5: Raising `chan_clr[c]` forces both stages of channel c to 0 at once, before the next system clock edge.
- R6: While `chan_clr[c]` is high, edges on the channel's count inputs are ignored. After the clear is released, counting resumes from 0.
- R7: Activity on one channel, including its clear, never changes the other channel's outputs.
- R8: A count input that changes before a system clock edge changes the output on the third rising edge of `clk` after that change, and not sooner.
- R9: With `out_two[c]` fed back to `tick_five[c]`, the channel counts 0 to 9 and wraps. The count value is out_two + 2·out_five.
- R10: With the quinary top bit fed back to `tick_two[c]`, the channel follows the biquinary order. The count value is 5·out_two + out_five.
- R11: With channel 0 in BCD, channel 0's quinary top bit feeding `tick_two[1]`, and channel 1 also in BCD, the pair counts 00 to 99 and wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| tick_two | input | NUM_CH | Count input of each binary stage; advances on a falling edge |
| tick_five | input | NUM_CH | Count input of each quinary stage; advances on a falling edge |
| chan_clr | input | NUM_CH | Clear of each channel, active high |
| out_two | output | NUM_CH | Binary stage output of each channel |
| out_five | output | 3*NUM_CH | Quinary count of each channel, 3 bits per channel |

## Verification
The assertions check the stepping rules of both state machines on every cycle. With an enable, the binary stage inverts and the quinary stage adds one or wraps from four to zero. Without an enable, both stages hold. A falling edge never produces an enable two cycles in a row. Only the bench scenarios can show the parts that depend on external wiring or on the ports: the three-edge latency, the BCD, biquinary and two-channel decimal orders, the immediate effect of a clear, and the isolation between channels.

// File: rtl/dbq_pkg.sv
package dbq_pkg;

    // Quinary stage states; the code is the count value driven on the outputs.
    typedef enum logic [2:0] {
        QS_ZERO  = 3'd0,
        QS_ONE   = 3'd1,
        QS_TWO   = 3'd2,
        QS_THREE = 3'd3,
        QS_FOUR  = 3'd4
    } quin_state_t;

    // Binary stage states.
    typedef enum logic {
        BS_LOW  = 1'b0,
        BS_HIGH = 1'b1
    } bin_state_t;

    localparam int unsigned QUIN_W = 3;

endpackage

// File: rtl/dbq_rst_sync.sv
module dbq_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic rst_a
);
    logic            arst;
    logic [STAGES-1:0] hold_q;

    assign arst = ~rst_n | clr;

    // Set at once, released only after STAGES clean edges of clk.
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            hold_q <= '1;
        end else begin
            hold_q <= {hold_q[STAGES-2:0], 1'b0};
        end
    end

    assign rst_a = hold_q[STAGES-1];

endmodule

// File: rtl/dbq_fall_detect.sv
module dbq_fall_detect #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_a,
    input  logic din,
    output logic fall
);
    localparam int unsigned PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] pipe_q;

    always_ff @(posedge clk or posedge rst_a) begin
        if (rst_a) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[PIPE_W-2:0], din};
        end
    end

    // Older sample high, newer sample low.
    assign fall = pipe_q[PIPE_W-1] & ~pipe_q[PIPE_W-2];

    AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst_a)
        fall |=> !fall); // R8

endmodule

// File: rtl/dbq_div2.sv
module dbq_div2
    import dbq_pkg::*;
(
    input  logic clk,
    input  logic rst_a,
    input  logic en,
    output logic q
);
    bin_state_t state_q;
    bin_state_t state_d;

    always_ff @(posedge clk or posedge rst_a) begin
        if (rst_a) begin
            state_q <= BS_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (en) begin
            unique case (state_q)
                BS_LOW:  state_d = BS_HIGH;
                BS_HIGH: state_d = BS_LOW;
                default: state_d = BS_LOW;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            BS_HIGH: q = 1'b1;
            default: q = 1'b0;
        endcase
    end

    AST_DIV2_INVERTS: assert property (@(posedge clk) disable iff (rst_a)
        en |=> (q != $past(q))); // R2
    AST_DIV2_HOLDS: assert property (@(posedge clk) disable iff (rst_a)
        !en |=> $stable(q)); // R4

endmodule

// File: rtl/dbq_div5.sv
module dbq_div5
    import dbq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_a,
    input  logic              en,
    output logic [QUIN_W-1:0] cnt
);
    quin_state_t state_q;
    quin_state_t state_d;

    always_ff @(posedge clk or posedge rst_a) begin
        if (rst_a) begin
            state_q <= QS_ZERO;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (en) begin
            unique case (state_q)
                QS_ZERO:  state_d = QS_ONE;
                QS_ONE:   state_d = QS_TWO;
                QS_TWO:   state_d = QS_THREE;
                QS_THREE: state_d = QS_FOUR;
                QS_FOUR:  state_d = QS_ZERO;
                default:  state_d = QS_ZERO;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            QS_ONE:   cnt = 3'd1;
            QS_TWO:   cnt = 3'd2;
            QS_THREE: cnt = 3'd3;
            QS_FOUR:  cnt = 3'd4;
            default:  cnt = 3'd0;
        endcase
    end

    AST_DIV5_STEP: assert property (@(posedge clk) disable iff (rst_a)
        (en && cnt != 3'd4) |=> (cnt == $past(cnt) + 3'd1)); // R3
    AST_DIV5_WRAP: assert property (@(posedge clk) disable iff (rst_a)
        (en && cnt == 3'd4) |=> (cnt == 3'd0)); // R3
    AST_DIV5_HOLDS: assert property (@(posedge clk) disable iff (rst_a)
        !en |=> $stable(cnt)); // R4
    AST_DIV5_RANGE: assert property (@(posedge clk) disable iff (rst_a)
        cnt <= 3'd4); // R3

endmodule

// File: rtl/dbq_channel.sv
module dbq_channel
    import dbq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_two,
    input  logic              tick_five,
    input  logic              clr,
    output logic              out_two,
    output logic [QUIN_W-1:0] out_five
);
    logic rst_a;
    logic en_two;
    logic en_five;

    dbq_rst_sync #(.STAGES(2)) u_rst (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .rst_a (rst_a)
    );

    dbq_fall_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge_two (
        .clk   (clk),
        .rst_a (rst_a),
        .din   (tick_two),
        .fall  (en_two)
    );

    dbq_fall_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge_five (
        .clk   (clk),
        .rst_a (rst_a),
        .din   (tick_five),
        .fall  (en_five)
    );

    dbq_div2 u_div2 (
        .clk   (clk),
        .rst_a (rst_a),
        .en    (en_two),
        .q     (out_two)
    );

    dbq_div5 u_div5 (
        .clk   (clk),
        .rst_a (rst_a),
        .en    (en_five),
        .cnt   (out_five)
    );

    AST_CLEAR_ZEROES: assert property (@(posedge clk)
        (rst_n && clr) |-> (!out_two && out_five == 3'd0)); // R5

endmodule

// File: rtl/dbq_dual_counter.sv
module dbq_dual_counter
    import dbq_pkg::*;
#(
    parameter int unsigned NUM_CH      = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH-1:0]          tick_two,
    input  logic [NUM_CH-1:0]          tick_five,
    input  logic [NUM_CH-1:0]          chan_clr,
    output logic [NUM_CH-1:0]          out_two,
    output logic [NUM_CH*QUIN_W-1:0]   out_five
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dbq_channel #(.SYNC_STAGES(SYNC_STAGES)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_two  (tick_two[c]),
            .tick_five (tick_five[c]),
            .clr       (chan_clr[c]),
            .out_two   (out_two[c]),
            .out_five  (out_five[c*QUIN_W +: QUIN_W])
        );
    end

endmodule

// File: tb/tb_dbq_dual_counter.sv
module tb_dbq_dual_counter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] two_drv = '0;
    logic [1:0] five_drv = '0;
    logic [1:0] chan_clr = '0;
    logic [1:0] tick_two;
    logic [1:0] tick_five;
    logic [1:0] out_two;
    logic [5:0] out_five;
    int         mode = 0;   // 0 direct, 1 BCD cascade, 2 biquinary on ch0
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    always_comb begin
        tick_two  = two_drv;
        tick_five = five_drv;
        if (mode == 1) begin
            tick_five[0] = out_two[0];
            tick_two[1]  = out_five[2];
            tick_five[1] = out_two[1];
        end else if (mode == 2) begin
            tick_two[0]  = out_five[2];
        end
    end

    dbq_dual_counter dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_two  (tick_two),
        .tick_five (tick_five),
        .chan_clr  (chan_clr),
        .out_two   (out_two),
        .out_five  (out_five)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int five(input int c);
        return int'(out_five[c*3 +: 3]);
    endfunction

    initial begin
        int two0;
        int ch1_snap;
        int ch0_snap;
        step(3);
        check("R1 in reset", int'({out_two, out_five}), 0);
        rst_n = 1'b1;
        step(5);
        check("R1 after release", int'({out_two, out_five}), 0);

        // R2 rising edge has no effect
        two_drv[0] = 1'b1;
        step(8);
        check("R2 rising edge", int'(out_two[0]), 0);
        // R8 latency: output moves on the third rising edge
        two_drv[0] = 1'b0;
        step(2);
        check("R8 before third edge", int'(out_two[0]), 0);
        step(1);
        check("R8 on third edge", int'(out_two[0]), 1);
        step(4);
        two0 = 1;

        // R2 / R4 / R7: pulses on the binary input of ch0
        for (int i = 0; i < 6; i++) begin
            two_drv[0] = 1'b1; step(6);
            two_drv[0] = 1'b0; step(6);
            two0++;
            check("R2 toggle", int'(out_two[0]), two0 % 2);
            check("R4 quinary untouched", five(0), 0);
            check("R7 other channel", int'({out_two[1], out_five[5:3]}), 0);
        end

        // R3 / R4 / R7: full quinary sweep on ch1
        for (int i = 1; i <= 12; i++) begin
            five_drv[1] = 1'b1; step(6);
            five_drv[1] = 1'b0; step(6);
            check("R3 quinary order", five(1), i % 5);
            check("R4 binary untouched", int'(out_two[1]), 0);
            check("R7 other channel", int'(out_two[0]), two0 % 2);
        end

        // R5 / R6 / R7: clear ch1 mid-count
        ch0_snap = int'({out_two[0], out_five[2:0]});
        chan_clr[1] = 1'b1;
        #1;
        check("R5 immediate clear", int'({out_two[1], out_five[5:3]}), 0);
        step(2);
        for (int i = 0; i < 3; i++) begin
            two_drv[1] = 1'b1; five_drv[1] = 1'b1; step(6);
            two_drv[1] = 1'b0; five_drv[1] = 1'b0; step(6);
            check("R6 edges ignored", int'({out_two[1], out_five[5:3]}), 0);
        end
        check("R7 clear isolation", int'({out_two[0], out_five[2:0]}), ch0_snap);
        chan_clr[1] = 1'b0;
        step(6);
        check("R6 zero after release", int'({out_two[1], out_five[5:3]}), 0);
        five_drv[1] = 1'b1; step(6);
        five_drv[1] = 1'b0; step(6);
        check("R6 resumes from zero", five(1), 1);

        // R9 / R11: two BCD decades chained
        chan_clr = 2'b11;
        step(2);
        two_drv = '0; five_drv = '0;
        mode = 1;
        step(2);
        chan_clr = 2'b00;
        step(6);
        for (int n = 1; n <= 100; n++) begin
            two_drv[0] = 1'b1; step(8);
            two_drv[0] = 1'b0; step(14);
            check("R9 decade units", int'(out_two[0]) + 2 * five(0), n % 10);
            check("R11 decade tens", int'(out_two[1]) + 2 * five(1), (n / 10) % 10);
        end

        // R10: biquinary order on ch0
        chan_clr = 2'b11;
        step(2);
        mode = 2;
        two_drv = '0; five_drv = '0;
        step(2);
        chan_clr = 2'b00;
        step(6);
        for (int n = 1; n <= 12; n++) begin
            five_drv[0] = 1'b1; step(8);
            five_drv[0] = 1'b0; step(12);
            check("R10 biquinary", 5 * int'(out_two[0]) + five(0), n % 10);
        end
        ch1_snap = int'({out_two[1], out_five[5:3]});
        check("R7 idle channel", ch1_snap, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule